// File: doc/BRIEF.md
# Outstanding Request Table with Alias Detection

This block sits between a processor port and a cache controller and keeps track of every memory request still in flight. Requests are split into two classes: reads (loads and instruction fetches) and writes (stores, read-modify-write halves and locked accesses). Each class has its own small associative table keyed by line address. Every presented request gets a status: Aliased if its line is already in flight, BufferFull if no room is left, or Ready. A Ready, well-formed request is accepted on the spot and stored with the current cycle number.

Completions come back with a line address and a class. They free the matching entry and report how many cycles the request spent in flight. Four stall counters record aliased request cycles, split by the class of the table that blocked the request and by the kind of the new request. The port retries a non-Ready request on later cycles, and each retry cycle counts again.

Top module: `ort_req_table`

## Requirements
- R1: Request kind encoding (3 bits): 0 load, 1 instruction fetch, 2 store, 3 RMW read, 4 RMW write, 5 locked read, 6 locked write. Kinds 2 to 6 go into the write table and kinds 0 and 1 into the read table. A completion with `cpl_is_write_i`=1 searches only the write table, and one with 0 searches only the read table.
- R2: The lookup key is the line address `req_addr_i[ADDR_W-1:OFF_W]`, where OFF_W = log2(LINE_BYTES). Two addresses in the same line alias each other whatever their offsets.
- R3: If the line is in the write table, `status_o` is Aliased (2'd1). On a valid request, `stall_st_ld_o` increments if the kind is load, fetch or RMW read; otherwise `stall_st_st_o` increments.
- R4: If the line is only in the read table, `status_o` is Aliased. On a valid request, `stall_ld_st_o` increments if the kind is store or RMW write; otherwise `stall_ld_ld_o` increments.
- R5: If there is no alias and either `count_o` >= MAX_OUT or the class table has no free entry, `status_o` is Full (2'd2). Otherwise it is Ready (2'd0).
- R6: `accept_o` = `req_valid_i` AND Ready AND legal. An accepted request occupies one entry from the next cycle onward, stamped with the current cycle.
- R7: A request is legal only when its offset plus `req_len_i` is at most LINE_BYTES. An illegal valid request is not accepted and raises `err_o` in the same cycle.
- R8: A completion that matches an entry frees that entry, decrements `count_o` on the next cycle, and in the same cycle drives `cpl_lat_o` with the current cycle minus the stamp (modulo 2^TS_W).
- R9: A completion with no matching entry raises `err_o`, drives `cpl_lat_o` to 0 and changes no state.
- R10: An acceptance and a matching completion in the same cycle leave `count_o` unchanged.
- R11: `count_o` always equals the number of valid entries in both tables. After reset, `count_o` and all stall counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request is presented |
| req_kind_i | input | 3 | Request kind (see R1) |
| req_addr_i | input | ADDR_W | Byte address of the request |
| req_len_i | input | LEN_W | Access length in bytes |
| status_o | output | 2 | 0 Ready, 1 Aliased, 2 Full |
| accept_o | output | 1 | Request allocated this cycle |
| cpl_valid_i | input | 1 | A completion is presented |
| cpl_is_write_i | input | 1 | Completion targets the write table |
| cpl_line_i | input | ADDR_W-OFF_W | Line address of the completion |
| cpl_lat_o | output | TS_W | Cycles the completed request was in flight |
| err_o | output | 1 | Illegal request or unmatched completion |
| count_o | output | CNT_W | Outstanding request count |
| stall_st_ld_o | output | CTR_W | Read-like request blocked by a write entry |
| stall_st_st_o | output | CTR_W | Other request blocked by a write entry |
| stall_ld_st_o | output | CTR_W | Store-like request blocked by a read entry |
| stall_ld_ld_o | output | CTR_W | Other request blocked by a read entry |

## Verification
An entry lost, duplicated or placed in the wrong class shows up within one cycle. A later request to that line gets the wrong status, a completion raises `err_o` when it should not (or fails to raise it), or the stall counter that moves is the wrong one. A stale or corrupted stamp shows up as a wrong `cpl_lat_o` in the cycle the entry completes. A count that drifts from the number of entries produces Full at the wrong occupancy. The bench keeps a shadow of both tables and compares status, acceptance, error, latency and count on every cycle. It compares the stall counters one cycle after each request.

// File: rtl/ort_pkg.sv
package ort_pkg;
  typedef enum logic [2:0] {
    K_LOAD    = 3'd0,
    K_IFETCH  = 3'd1,
    K_STORE   = 3'd2,
    K_RMW_RD  = 3'd3,
    K_RMW_WR  = 3'd4,
    K_LOCK_RD = 3'd5,
    K_LOCK_WR = 3'd6
  } req_kind_e;

  typedef enum logic [1:0] {
    S_READY = 2'd0,
    S_ALIAS = 2'd1,
    S_FULL  = 2'd2
  } req_status_e;

  function automatic logic is_wr_class(input logic [2:0] k);
    return (k >= 3'd2) && (k <= 3'd6);
  endfunction

  function automatic logic is_ld_like(input logic [2:0] k);
    return (k == 3'd0) || (k == 3'd1) || (k == 3'd3);
  endfunction

  function automatic logic is_st_like(input logic [2:0] k);
    return (k == 3'd2) || (k == 3'd4);
  endfunction
endpackage

// File: rtl/ort_table.sv
module ort_table #(
  parameter int DEPTH  = 4,
  parameter int LINE_W = 12,
  parameter int TS_W   = 12,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] look_line_i,
  output logic              look_hit_o,
  output logic              has_free_o,
  input  logic              alloc_i,
  input  logic [TS_W-1:0]   now_i,
  input  logic              free_i,
  input  logic [LINE_W-1:0] free_line_i,
  output logic              free_hit_o,
  output logic [TS_W-1:0]   free_stamp_o,
  output logic [CNT_W-1:0]  used_o
);
  logic [DEPTH-1:0]  vld_q;
  logic [LINE_W-1:0] line_q  [DEPTH];
  logic [TS_W-1:0]   stamp_q [DEPTH];
  logic [DEPTH-1:0]  look_match, free_match, slot_oh;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign look_match[g] = vld_q[g] && (line_q[g] == look_line_i);
    assign free_match[g] = vld_q[g] && (line_q[g] == free_line_i);
  end

  assign look_hit_o = |look_match;
  assign free_hit_o = free_i && (|free_match);

  // lowest free index wins
  always_comb begin
    slot_oh    = '0;
    has_free_o = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        slot_oh    = '0;
        slot_oh[i] = 1'b1;
        has_free_o = 1'b1;
      end
    end
  end

  always_comb begin
    free_stamp_o = '0;
    used_o       = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (free_match[i]) free_stamp_o = free_stamp_o | stamp_q[i];
      used_o = used_o + CNT_W'(vld_q[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (free_i && free_match[i]) vld_q[i] <= 1'b0;
        if (alloc_i && slot_oh[i])   vld_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc_i && slot_oh[i]) begin
        line_q[i]  <= look_line_i;
        stamp_q[i] <= now_i;
      end
    end
  end

  AST_NO_DUP_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(look_match)) else $error("duplicate line in table"); // R2
  AST_ALLOC_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> (has_free_o && !look_hit_o)) else $error("bad allocation"); // R6
endmodule

// File: rtl/ort_stall_ctrs.sv
module ort_stall_ctrs #(
  parameter int NUM   = 4,
  parameter int CTR_W = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM-1:0]            inc_i,
  output logic [NUM-1:0][CTR_W-1:0] cnt_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_ctr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_o[g] <= '0;
      else if (inc_i[g]) cnt_o[g] <= cnt_o[g] + CTR_W'(1);
    end
  end

  AST_ONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(inc_i)) else $error("two stall causes at once"); // R3
endmodule

// File: rtl/ort_req_table.sv
module ort_req_table
  import ort_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 16,
  parameter int LEN_W      = 5,
  parameter int RD_DEPTH   = 4,
  parameter int WR_DEPTH   = 4,
  parameter int MAX_OUT    = 6,
  parameter int TS_W       = 12,
  parameter int CTR_W      = 16,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - OFF_W,
  localparam int CNT_W     = $clog2(RD_DEPTH + WR_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic [1:0]        status_o,
  output logic              accept_o,
  input  logic              cpl_valid_i,
  input  logic              cpl_is_write_i,
  input  logic [LINE_W-1:0] cpl_line_i,
  output logic [TS_W-1:0]   cpl_lat_o,
  output logic              err_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CTR_W-1:0]  stall_st_ld_o,
  output logic [CTR_W-1:0]  stall_st_st_o,
  output logic [CTR_W-1:0]  stall_ld_st_o,
  output logic [CTR_W-1:0]  stall_ld_ld_o
);
  localparam int RD_CW = $clog2(RD_DEPTH + 1);
  localparam int WR_CW = $clog2(WR_DEPTH + 1);

  logic [LINE_W-1:0] req_line;
  logic [OFF_W-1:0]  req_off;
  logic              req_wr, legal;
  logic              rd_hit, wr_hit, rd_free, wr_free;
  logic              rd_fhit, wr_fhit, cpl_hit;
  logic [TS_W-1:0]   rd_stamp, wr_stamp, now_q;
  logic [RD_CW-1:0]  rd_used;
  logic [WR_CW-1:0]  wr_used;
  logic [CNT_W-1:0]  count_q;
  logic              ready;
  logic [3:0]        stall_inc;
  logic [3:0][CTR_W-1:0] stall_cnt;

  assign req_line = req_addr_i[ADDR_W-1:OFF_W];
  assign req_off  = req_addr_i[OFF_W-1:0];
  assign req_wr   = is_wr_class(req_kind_i);
  assign legal    = (32'(req_off) + 32'(req_len_i)) <= 32'(LINE_BYTES);

  ort_table #(.DEPTH(RD_DEPTH), .LINE_W(LINE_W), .TS_W(TS_W)) u_rd_tbl (
    .clk_i, .rst_ni,
    .look_line_i (req_line),
    .look_hit_o  (rd_hit),
    .has_free_o  (rd_free),
    .alloc_i     (accept_o && !req_wr),
    .now_i       (now_q),
    .free_i      (cpl_valid_i && !cpl_is_write_i),
    .free_line_i (cpl_line_i),
    .free_hit_o  (rd_fhit),
    .free_stamp_o(rd_stamp),
    .used_o      (rd_used)
  );

  ort_table #(.DEPTH(WR_DEPTH), .LINE_W(LINE_W), .TS_W(TS_W)) u_wr_tbl (
    .clk_i, .rst_ni,
    .look_line_i (req_line),
    .look_hit_o  (wr_hit),
    .has_free_o  (wr_free),
    .alloc_i     (accept_o && req_wr),
    .now_i       (now_q),
    .free_i      (cpl_valid_i && cpl_is_write_i),
    .free_line_i (cpl_line_i),
    .free_hit_o  (wr_fhit),
    .free_stamp_o(wr_stamp),
    .used_o      (wr_used)
  );

  // write-table conflicts take priority over read-table conflicts
  always_comb begin
    if (wr_hit || rd_hit)
      status_o = S_ALIAS;
    else if ((32'(count_q) >= 32'(MAX_OUT)) || (req_wr ? !wr_free : !rd_free))
      status_o = S_FULL;
    else
      status_o = S_READY;
  end

  assign ready    = (status_o == S_READY);
  assign accept_o = req_valid_i && ready && legal;

  assign cpl_hit   = cpl_is_write_i ? wr_fhit : rd_fhit;
  assign cpl_lat_o = !cpl_hit ? '0 :
                     (now_q - (cpl_is_write_i ? wr_stamp : rd_stamp));
  assign err_o     = (req_valid_i && !legal) || (cpl_valid_i && !cpl_hit);

  assign stall_inc[0] = req_valid_i && wr_hit && is_ld_like(req_kind_i);
  assign stall_inc[1] = req_valid_i && wr_hit && !is_ld_like(req_kind_i);
  assign stall_inc[2] = req_valid_i && !wr_hit && rd_hit && is_st_like(req_kind_i);
  assign stall_inc[3] = req_valid_i && !wr_hit && rd_hit && !is_st_like(req_kind_i);

  ort_stall_ctrs #(.NUM(4), .CTR_W(CTR_W)) u_ctrs (
    .clk_i, .rst_ni,
    .inc_i (stall_inc),
    .cnt_o (stall_cnt)
  );

  assign stall_st_ld_o = stall_cnt[0];
  assign stall_st_st_o = stall_cnt[1];
  assign stall_ld_st_o = stall_cnt[2];
  assign stall_ld_ld_o = stall_cnt[3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      now_q   <= '0;
    end else begin
      count_q <= count_q + CNT_W'(accept_o) - CNT_W'(cpl_hit);
      now_q   <= now_q + TS_W'(1);
    end
  end

  assign count_o = count_q;

  AST_COUNT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(count_q) == 32'(rd_used) + 32'(wr_used)) else $error("count drift"); // R11
  AST_COUNT_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(count_q) <= 32'(MAX_OUT)) else $error("count above limit"); // R5
  AST_MISS_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_valid_i && !cpl_hit && !accept_o) |=> $stable(count_q))
    else $error("unmatched completion changed state"); // R9
  AST_ILLEGAL_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !legal) |-> (!accept_o && err_o))
    else $error("illegal request accepted"); // R7
endmodule

// File: tb/ort_req_table_tb.sv
module ort_req_table_tb;
  localparam int DEPTH   = 4;
  localparam int MAX_OUT = 6;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [2:0]  req_kind_i = '0;
  logic [15:0] req_addr_i = '0;
  logic [4:0]  req_len_i = '0;
  logic [1:0]  status_o;
  logic        accept_o;
  logic        cpl_valid_i = 1'b0;
  logic        cpl_is_write_i = 1'b0;
  logic [11:0] cpl_line_i = '0;
  logic [11:0] cpl_lat_o;
  logic        err_o;
  logic [3:0]  count_o;
  logic [15:0] stall_st_ld_o, stall_st_st_o, stall_ld_st_o, stall_ld_ld_o;

  ort_req_table u_dut (
    .clk_i(clk), .rst_ni,
    .req_valid_i, .req_kind_i, .req_addr_i, .req_len_i,
    .status_o, .accept_o,
    .cpl_valid_i, .cpl_is_write_i, .cpl_line_i, .cpl_lat_o,
    .err_o, .count_o,
    .stall_st_ld_o, .stall_st_st_o, .stall_ld_st_o, .stall_ld_ld_o
  );

  always #4 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // shadow tables: [0] read, [1] write
  bit  m_v    [2][DEPTH];
  int  m_line [2][DEPTH];
  int  m_ts   [2][DEPTH];
  int  m_ctr  [4];
  int  tb_now;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int find(input int cls, input int line);
    for (int i = 0; i < DEPTH; i++)
      if (m_v[cls][i] && m_line[cls][i] == line) return i;
    return -1;
  endfunction

  function automatic int used(input int cls);
    int n = 0;
    for (int i = 0; i < DEPTH; i++) if (m_v[cls][i]) n++;
    return n;
  endfunction

  function automatic bit wr_kind(input int k); return k >= 2 && k <= 6; endfunction
  function automatic bit ld_like(input int k); return k == 0 || k == 1 || k == 3; endfunction
  function automatic bit st_like(input int k); return k == 2 || k == 4; endfunction

  task automatic step(input bit rv, input int k, input int addr, input int len,
                      input bit cv, input bit cw, input int cl);
    int line, cls, wi, ri, ci, exp_st, cnt, lat;
    bit legal, acc, err;
    req_valid_i = rv; req_kind_i = 3'(k); req_addr_i = 16'(addr); req_len_i = 5'(len);
    cpl_valid_i = cv; cpl_is_write_i = cw; cpl_line_i = 12'(cl);
    #1;
    line  = (addr >> 4) & 12'hfff;
    cls   = wr_kind(k) ? 1 : 0;
    wi    = find(1, line);
    ri    = find(0, line);
    cnt   = used(0) + used(1);
    legal = ((addr & 15) + len) <= 16;
    if (wi >= 0 || ri >= 0) exp_st = 1;
    else if (cnt >= MAX_OUT || used(cls) == DEPTH) exp_st = 2;
    else exp_st = 0;
    acc = rv && exp_st == 0 && legal;
    ci  = cv ? find(cw ? 1 : 0, cl) : -1;
    err = (rv && !legal) || (cv && ci < 0);
    lat = (ci >= 0) ? ((tb_now - m_ts[cw ? 1 : 0][ci]) & 12'hfff) : 0;
    chk("R3/R4/R5 status", int'(status_o), exp_st);
    chk("R6 accept", int'(accept_o), int'(acc));
    chk("R7/R9 err", int'(err_o), int'(err));
    chk("R8 latency", int'(cpl_lat_o), lat);
    @(posedge clk);
    if (rv && wi >= 0) begin
      if (ld_like(k)) m_ctr[0]++; else m_ctr[1]++;
    end else if (rv && ri >= 0) begin
      if (st_like(k)) m_ctr[2]++; else m_ctr[3]++;
    end
    if (ci >= 0) m_v[cw ? 1 : 0][ci] = 1'b0;
    if (acc) begin
      for (int i = 0; i < DEPTH; i++)
        if (!m_v[cls][i]) begin
          m_v[cls][i] = 1'b1; m_line[cls][i] = line; m_ts[cls][i] = tb_now;
          break;
        end
    end
    tb_now++;
    @(negedge clk);
    chk("R11 count", int'(count_o), used(0) + used(1));
    chk("R3 stall_st_ld", int'(stall_st_ld_o), m_ctr[0] & 16'hffff);
    chk("R3 stall_st_st", int'(stall_st_st_o), m_ctr[1] & 16'hffff);
    chk("R4 stall_ld_st", int'(stall_ld_st_o), m_ctr[2] & 16'hffff);
    chk("R4 stall_ld_ld", int'(stall_ld_ld_o), m_ctr[3] & 16'hffff);
  endtask

  task automatic idle();
    step(0, 0, 0, 1, 0, 0, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int c = 0; c < 2; c++) for (int i = 0; i < DEPTH; i++) m_v[c][i] = 1'b0;
    for (int i = 0; i < 4; i++) m_ctr[i] = 0;
    tb_now = 0;
    repeat (3) @(negedge clk);
    chk("R11 reset count", int'(count_o), 0);
    chk("R11 reset stall", int'(stall_st_ld_o | stall_st_st_o | stall_ld_st_o | stall_ld_ld_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1/R5: four loads fill the read table, fifth load is Full
    for (int i = 0; i < 4; i++) step(1, i % 2, (16'h100 + i) << 4, 4, 0, 0, 0);
    step(1, 0, 16'h200 << 4, 4, 0, 0, 0);
    // R5: two stores reach MAX_OUT, third store Full with write table not full
    step(1, 2, 16'h300 << 4, 8, 0, 0, 0);
    step(1, 6, 16'h301 << 4, 8, 0, 0, 0);
    step(1, 2, 16'h302 << 4, 8, 0, 0, 0);
    // R2/R3: load into a write-held line at another offset -> Aliased, st_ld
    step(1, 0, (16'h300 << 4) | 5, 2, 0, 0, 0);
    step(1, 4, (16'h301 << 4) | 9, 2, 0, 0, 0);
    // R4: store into read-held line -> ld_st, fetch -> ld_ld
    step(1, 2, 16'h101 << 4, 2, 0, 0, 0);
    step(1, 1, 16'h102 << 4, 2, 0, 0, 0);
    // R1: write completion on a read-held line misses (R9)
    step(0, 0, 0, 1, 1, 1, 16'h100);
    // R8: matching completions with latency
    step(0, 0, 0, 1, 1, 0, 16'h100);
    step(0, 0, 0, 1, 1, 1, 16'h300);
    // R10: accept and complete in the same cycle
    step(1, 3, 16'h400 << 4, 4, 1, 0, 16'h101);
    // R7: illegal span (offset 12 + 5 bytes)
    step(1, 0, (16'h500 << 4) | 12, 5, 0, 0, 0);
    step(1, 0, (16'h500 << 4) | 12, 4, 0, 0, 0);
    // drain everything
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < DEPTH; i++)
        if (m_v[c][i]) step(0, 0, 0, 1, 1, bit'(c), m_line[c][i]);
    idle();

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      bit rv, cv, cw;
      int k, addr, len, cl, pick;
      rv   = ($urandom % 10) < 7;
      k    = $urandom % 7;
      addr = ((($urandom % 8) + 16'h40) << 4) | ($urandom % 16);
      len  = 1 + ($urandom % 16);
      cv   = ($urandom % 10) < 4;
      cw   = $urandom % 2;
      cl   = ($urandom % 8) + 16'h40;
      if (cv && ($urandom % 100) < 85) begin
        pick = $urandom % (2 * DEPTH);
        if (m_v[pick / DEPTH][pick % DEPTH]) begin
          cw = bit'(pick / DEPTH);
          cl = m_line[pick / DEPTH][pick % DEPTH];
        end
      end
      step(rv, k, addr, len, cv, cw, cl);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule